// File: doc/BRIEF.md
# Multiplexed Button Matrix Register

This block is a byte-wide input register for a small keypad of eight buttons. The buttons are split into two groups of four: a directional group (right, left, up, down) and an action group (A, B, select, start). Software writes two active-low select bits to choose which group or groups drive the low nibble of the register. Each nibble bit is the wired-AND of the selected groups, and it reads 0 while a selected button on that line is pressed.

The raw button inputs are active-high (1 = pressed) and pass through a two-stage synchroniser before they are used. The select bits are held in a four-state register (`SEL_BOTH`, `SEL_DIR`, `SEL_ACT`, `SEL_NONE`). Any bus write moves it straight to the state encoded by write bits 5:4, and it holds its state when no write occurs. Reset enters `SEL_BOTH`. When any nibble bit falls from 1 to 0, a one-cycle interrupt pulse is raised. This can come from a press or from a select change.

Top module: `btn_matrix_reg`

## Requirements
- R1: A write with `wr_en` high updates only register bits 5:4 from `wr_data[5:4]`. Written bits 7:6 and 3:0 have no effect on what is read back.
- R2: Read bits 7:6 are always 1.
- R3: With bit 4 = 0 (directional selected), nibble bit n reads 0 while directional button n is pressed. The lines map as `btn_raw[0]` right to bit 0, `[1]` left to bit 1, `[2]` up to bit 2, and `[3]` down to bit 3.
- R4: With bit 5 = 0 (action selected), nibble bit n reads 0 while action button n is pressed. The lines map as `btn_raw[4]` A to bit 0, `[5]` B to bit 1, `[6]` select to bit 2, and `[7]` start to bit 3.
- R5: With both select bits at 0, a nibble bit reads 0 when the button of either group on that line is pressed.
- R6: With both select bits at 1, the nibble reads 0xF whatever buttons are pressed.
- R7: After reset, with no button pressed, the register reads 0xCF.
- R8: A change on `btn_raw` appears in `rd_data` after exactly two rising clock edges.
- R9: `irq` is high for exactly one cycle, starting one edge after any nibble bit falls from 1 to 0. A rise of a nibble bit (release) raises no pulse.
- R10: Buttons of a deselected group do not affect the nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Bus write data; only bits 5:4 are used |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Register read value |
| btn_raw | input | 8 | Asynchronous buttons, 1 = pressed; [3:0] directional, [7:4] action |
| irq | output | 1 | One-cycle pulse on a nibble falling bit |

## Verification
The hardest case to reach is the exact cycle at which a press becomes visible and the pulse that follows it. To reach it, the bench changes one button at a falling edge. It then probes the nibble after one edge (unchanged) and after two edges (changed), and probes `irq` on each of the next two cycles. It then releases the button and watches `irq` stay low, which shows that a release raises no pulse. Masking is reached by pressing both groups at once and then stepping through all four select states.

// File: rtl/btn_pkg.sv
package btn_pkg;
    localparam int LINES = 4;
    localparam int BTNS  = 2 * LINES;

    // encoding equals {bit5, bit4} of the register; 0 selects a group
    typedef enum logic [1:0] {
        SEL_BOTH = 2'b00,
        SEL_ACT  = 2'b01,
        SEL_DIR  = 2'b10,
        SEL_NONE = 2'b11
    } sel_mode_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/btn_line_mux.sv
module btn_line_mux #(
    parameter int LINES = 4
) (
    input  logic [2*LINES-1:0] btn,
    input  logic               dir_en,
    input  logic               act_en,
    output logic [LINES-1:0]   line_n
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic dir_hit;
        logic act_hit;
        assign dir_hit   = dir_en & btn[i];
        assign act_hit   = act_en & btn[LINES+i];
        assign line_n[i] = ~(dir_hit | act_hit);
    end
endmodule

// File: rtl/fall_pulse.sv
module fall_pulse #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig,
    output logic             pulse
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
            pulse  <= 1'b0;
        end else begin
            prev_q <= sig;
            pulse  <= |(prev_q & ~sig);
        end
    end

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (|($past(sig, 2) & ~$past(sig, 1)))); // R9
endmodule

// File: rtl/btn_matrix_reg.sv
module btn_matrix_reg
    import btn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wr_data,
    input  logic       wr_en,
    output logic [7:0] rd_data,
    input  logic [7:0] btn_raw,
    output logic       irq
);
    sel_mode_e        state_q, state_d;
    logic             dir_en, act_en;
    logic [BTNS-1:0]  btn_s;
    logic [LINES-1:0] line_n;

    // next state: a write jumps to the encoded select state
    always_comb begin
        state_d = state_q;
        if (wr_en) state_d = sel_mode_e'(wr_data[5:4]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_BOTH;
        else        state_q <= state_d;
    end

    // outputs per state
    always_comb begin
        dir_en = 1'b0;
        act_en = 1'b0;
        unique case (state_q)
            SEL_BOTH: begin dir_en = 1'b1; act_en = 1'b1; end
            SEL_DIR:  dir_en = 1'b1;
            SEL_ACT:  act_en = 1'b1;
            SEL_NONE: ;
        endcase
    end

    btn_sync #(.WIDTH(BTNS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(btn_raw), .q(btn_s)
    );

    btn_line_mux #(.LINES(LINES)) u_mux (
        .btn(btn_s), .dir_en(dir_en), .act_en(act_en), .line_n(line_n)
    );

    fall_pulse #(.WIDTH(LINES)) u_irq (
        .clk(clk), .rst_n(rst_n), .sig(line_n), .pulse(irq)
    );

    assign rd_data = {2'b11, state_q, line_n};

    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[5:4] == $past(wr_data[5:4])); // R1
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[5:4])); // R1
    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5:4] == 2'b11) |-> (rd_data[3:0] == 4'hF)); // R6
endmodule

// File: tb/sim_btn_matrix_reg.sv
module sim_btn_matrix_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] btn_raw = 8'h00;
    logic       irq;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    btn_matrix_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
        .rd_data(rd_data), .btn_raw(btn_raw), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [1:0] sel, input logic [7:0] b);
        logic [3:0] n;
        n = ~(((sel[0] == 1'b0) ? b[3:0] : 4'h0) | ((sel[1] == 1'b0) ? b[7:4] : 4'h0));
        return {2'b11, sel, n};
    endfunction

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_data = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic press(input logic [7:0] v);
        @(negedge clk); btn_raw = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R7 reset", rd_data, 8'hCF);
        chk("R2 top bits", {6'h0, rd_data[7:6]}, 8'h03);
    endtask

    task automatic t_write_mask;
        press(8'h00);
        wr(8'h2F);                       // junk in 7:6 and 3:0, select dir
        chk("R1 write mask", rd_data, 8'hEF);
        wr(8'h10);                       // 7:6 written 0 must still read 1
        chk("R2 after write", rd_data, 8'hDF);
        wr(8'hC0);
        chk("R1 both again", rd_data, 8'hCF);
    endtask

    task automatic t_dir;
        wr(8'h20);
        for (int i = 0; i < 4; i++) begin
            press(8'h01 << i);
            chk("R3 dir line", rd_data, model(2'b10, 8'h01 << i));
        end
        press(8'hF0);                    // action pressed, deselected
        chk("R10 act ignored", rd_data, 8'hEF);
    endtask

    task automatic t_act;
        wr(8'h10);
        for (int i = 0; i < 4; i++) begin
            press(8'h10 << i);
            chk("R4 act line", rd_data, model(2'b01, 8'h10 << i));
        end
        press(8'h0F);
        chk("R10 dir ignored", rd_data, 8'hDF);
    endtask

    task automatic t_both;
        wr(8'h00);
        press(8'h81);                    // right + start
        chk("R5 wired and", rd_data, 8'hC6);
        press(8'h24);                    // up + B
        chk("R5 mixed", rd_data, model(2'b00, 8'h24));
    endtask

    task automatic t_none;
        wr(8'h30);
        press(8'hFF);
        chk("R6 none selected", rd_data, 8'hFF);
        wr(8'h20);
        chk("R3 reselect dir", rd_data, 8'hE0);
    endtask

    task automatic t_latency_irq;
        int seen;
        wr(8'h20);
        press(8'h00);
        repeat (3) @(negedge clk);
        btn_raw = 8'h08;                 // down
        @(negedge clk);
        chk("R8 one edge", rd_data, 8'hEF);
        @(negedge clk);
        chk("R8 two edges", rd_data, 8'hE7);
        chk("R9 not yet", {7'h0, irq}, 8'h00);
        @(negedge clk);
        chk("R9 pulse", {7'h0, irq}, 8'h01);
        @(negedge clk);
        chk("R9 one cycle", {7'h0, irq}, 8'h00);
        btn_raw = 8'h00;
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (irq) seen++;
        end
        chk("R9 release silent", seen[7:0], 8'h00);
    endtask

    initial begin
        #500us;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_mask();
        t_dir();
        t_act();
        t_both();
        t_none();
        t_latency_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule